// File: doc/BRIEF.md
# Two-Channel Reload-Counter Bit-Rate Generator

This block derives serial bit-rate timing for two independent channels from the system clock. Each channel owns a free-running 10-bit up-counter. When the counter reaches its all-ones value, it reloads itself from a software-programmed 10-bit value and emits one prescale pulse. A prescale period is therefore `1024 - REL` clocks long. The reload value is written as two bytes: a low byte carrying bits 7:0 and a high byte whose two least significant bits carry bits 9:8.

Prescale pulses pass through a small pre-divider and then a divide-by-16 stage. This yields two single-cycle outputs per channel: an oversample tick at 16 times the bit rate, and a bit tick at the bit rate. Channel 0 has a rate-doubling control that halves its pre-divider. It can also take its prescale pulses from an external timer-overflow input instead of its own counter. Channel 1 always uses its own counter and a fixed pre-divide of 2, so its bit period is `32 x (1024 - REL1)` clocks. The serial shifters consume the ticks.

Software uses a simple write port and a read port with one cycle of latency. A reload write never shortens the prescale period already running.

Top module: `serial_rate_gen`

## Requirements
- R1: The register map is: address 0 is the channel 0 low byte, address 1 is the channel 0 high byte, address 2 is the channel 1 low byte, address 3 is the channel 1 high byte, and address 4 is control. Control bit 0 is the double bit and control bit 1 is the timer-source select. The reload value is {high[1:0], low[7:0]}. Reads return `rd_data` one clock after `rd_addr` is presented. Unused high-byte and control bits read as 0, and any other address reads 0.
- R2: Each channel's counter counts up by one per clock, and from 1023 reloads the programmed value. The prescale pulse period is therefore 1024 - REL clocks.
- R3: With the timer source deselected, channel 0 emits an oversample tick every 4 x (1024 - REL0) clocks when double = 0, and every 2 x (1024 - REL0) clocks when double = 1.
- R4: With the timer source selected, channel 0 emits an oversample tick every second pulse on `t1_ovf` when double = 0, and on every pulse when double = 1.
- R5: Channel 1 emits an oversample tick every 2 x (1024 - REL1) clocks, regardless of the double bit, the timer-source select and `t1_ovf`.
- R6: A bit tick occurs in the same cycle as every 16th oversample tick of its channel, and at no other time.
- R7: Bit ticks are one clock wide.
- R8: A reload write applies starting with the next reload of the counter. A write sampled on the same clock edge as a reload applies only from the following reload.
- R9: Synchronous reset clears both reload values and both control bits to 0, starts both counters at 0, and drives all ticks low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| t1_ovf | input | 1 | Timer overflow pulse, alternative source for channel 0 |
| ch0_os_tick | output | 1 | Channel 0 oversample tick |
| ch0_bit_tick | output | 1 | Channel 0 bit tick |
| ch1_os_tick | output | 1 | Channel 1 oversample tick |
| ch1_bit_tick | output | 1 | Channel 1 bit tick |

## Verification
A software reload write and a counter reload can land on the same clock edge. The design must then load the previously held value and apply the new one only from the next reload. The bench infers the channel 1 counter phase from an observed oversample tick, which trails the reload edge by one cycle. It then places a low-byte write exactly on the following reload edge, and separately places another write a few cycles into a period. The interval pairs that follow are judged against sums of old and new periods computed in the bench. The bench also checks the bit tick, which always coincides with an oversample tick, on every occurrence.

// File: rtl/srg_pkg.sv
package srg_pkg;

  localparam int REL_W  = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_REL0_LO = 3'd0,
    A_REL0_HI = 3'd1,
    A_REL1_LO = 3'd2,
    A_REL1_HI = 3'd3,
    A_CTRL    = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic t1_src;
    logic dbl;
  } ctrl_t;

endpackage

// File: rtl/srg_regs.sv
module srg_regs
  import srg_pkg::*;
#(
  parameter int RW = 10,
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [RW-1:0] rel0,
  output logic [RW-1:0] rel1,
  output ctrl_t         ctrl
);
  localparam int HW = RW - DW;
  localparam int CW = $bits(ctrl_t);

  logic [DW-1:0] lo0, lo1;
  logic [HW-1:0] hi0, hi1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo0  <= '0;
      lo1  <= '0;
      hi0  <= '0;
      hi1  <= '0;
      ctrl <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_REL0_LO: lo0  <= wr_data;
        A_REL0_HI: hi0  <= wr_data[HW-1:0];
        A_REL1_LO: lo1  <= wr_data;
        A_REL1_HI: hi1  <= wr_data[HW-1:0];
        A_CTRL:    ctrl <= ctrl_t'(wr_data[CW-1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_REL0_LO: rd_data <= lo0;
        A_REL0_HI: rd_data <= {{(DW-HW){1'b0}}, hi0};
        A_REL1_LO: rd_data <= lo1;
        A_REL1_HI: rd_data <= {{(DW-HW){1'b0}}, hi1};
        A_CTRL:    rd_data <= {{(DW-CW){1'b0}}, ctrl};
        default:   rd_data <= '0;
      endcase
    end
  end

  assign rel0 = {hi0, lo0};
  assign rel1 = {hi1, lo1};

  // R1
  hi0_field_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_REL0_HI) |=> rel0[RW-1:DW] == $past(wr_data[HW-1:0]));

  // R1
  lo1_field_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_REL1_LO) |=> rel1[DW-1:0] == $past(wr_data));

endmodule

// File: rtl/srg_reload_ctr.sv
module srg_reload_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rel,
  output logic         pulse
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == TOP) begin
      cnt   <= rel;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end
  end

  // R8: reload takes the value held before the reload edge
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |-> cnt == $past(rel));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!pulse && !$past(rst)) |-> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/srg_tick_div.sv
module srg_tick_div #(
  parameter int PRE_W    = 3,
  parameter int OS_RATIO = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_pulse,
  input  logic [PRE_W-1:0] pre_div,
  output logic             os_tick,
  output logic             bit_tick
);
  localparam int OS_W = $clog2(OS_RATIO);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATIO - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [OS_W-1:0]  os_cnt;
  logic             pre_wrap;

  assign pre_wrap = pre_cnt >= (pre_div - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      os_cnt   <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
      if (src_pulse) begin
        if (pre_wrap) begin
          pre_cnt <= '0;
          os_tick <= 1'b1;
          if (os_cnt == OS_LAST) begin
            os_cnt   <= '0;
            bit_tick <= 1'b1;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  // R6
  bit_with_os_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);

  // R7
  bit_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);

  // R3
  os_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    os_tick |-> $past(src_pulse));

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import srg_pkg::*;
#(
  parameter int REL_BITS  = REL_W,
  parameter int DATA_BITS = DATA_W,
  parameter int ADDR_BITS = ADDR_W,
  parameter int OS_RATIO  = 16,
  parameter int PRE_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic [DATA_BITS-1:0] rd_data,
  input  logic                 t1_ovf,
  output logic                 ch0_os_tick,
  output logic                 ch0_bit_tick,
  output logic                 ch1_os_tick,
  output logic                 ch1_bit_tick
);
  localparam int NCH = 2;
  localparam logic [PRE_W-1:0] PRE_INT_SLOW = PRE_W'(4);
  localparam logic [PRE_W-1:0] PRE_INT_FAST = PRE_W'(2);
  localparam logic [PRE_W-1:0] PRE_T1_SLOW  = PRE_W'(2);
  localparam logic [PRE_W-1:0] PRE_T1_FAST  = PRE_W'(1);
  localparam logic [PRE_W-1:0] PRE_CH1      = PRE_W'(2);

  logic [REL_BITS-1:0] rel [NCH];
  logic [NCH-1:0]      ctr_pulse;
  logic [NCH-1:0]      src_pulse;
  logic [PRE_W-1:0]    pre_div [NCH];
  logic [NCH-1:0]      os_tick;
  logic [NCH-1:0]      bit_tick;
  ctrl_t               ctrl;
  logic                t1_q;

  srg_regs #(.RW(REL_BITS), .DW(DATA_BITS), .AW(ADDR_BITS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rel0    (rel[0]),
    .rel1    (rel[1]),
    .ctrl    (ctrl)
  );

  // Timer overflow aligned to the counter pulse stage
  always_ff @(posedge clk) begin
    if (rst) t1_q <= 1'b0;
    else     t1_q <= t1_ovf;
  end

  always_comb begin
    src_pulse[0] = ctrl.t1_src ? t1_q : ctr_pulse[0];
    if (ctrl.t1_src) pre_div[0] = ctrl.dbl ? PRE_T1_FAST : PRE_T1_SLOW;
    else             pre_div[0] = ctrl.dbl ? PRE_INT_FAST : PRE_INT_SLOW;
    src_pulse[1] = ctr_pulse[1];
    pre_div[1]   = PRE_CH1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    srg_reload_ctr #(.W(REL_BITS)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .rel   (rel[g]),
      .pulse (ctr_pulse[g])
    );
    srg_tick_div #(.PRE_W(PRE_W), .OS_RATIO(OS_RATIO)) u_div (
      .clk       (clk),
      .rst       (rst),
      .src_pulse (src_pulse[g]),
      .pre_div   (pre_div[g]),
      .os_tick   (os_tick[g]),
      .bit_tick  (bit_tick[g])
    );
  end

  assign ch0_os_tick  = os_tick[0];
  assign ch0_bit_tick = bit_tick[0];
  assign ch1_os_tick  = os_tick[1];
  assign ch1_bit_tick = bit_tick[1];

  // R5: channel 1 ticks only follow its own counter pulse
  ch1_own_src_chk: assert property (@(posedge clk) disable iff (rst)
    ch1_os_tick |-> $past(ctr_pulse[1]));

  // R4: timer-sourced channel 0 ticks follow a timer overflow
  ch0_t1_src_chk: assert property (@(posedge clk) disable iff (rst)
    (ch0_os_tick && $past(ctrl.t1_src)) |-> $past(t1_q));

endmodule

// File: tb/tb_serial_rate_gen.sv
module tb_serial_rate_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       t1_ovf = 1'b0;
  logic       ch0_os_tick, ch0_bit_tick, ch1_os_tick, ch1_bit_tick;

  int  checks = 0;
  int  errs = 0;
  int  cyc = 0;
  int  t1_per = 4;
  int  t1_cnt = 0;
  int  os_since0 = 0;
  int  os_since1 = 0;

  serial_rate_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .t1_ovf(t1_ovf),
    .ch0_os_tick(ch0_os_tick), .ch0_bit_tick(ch0_bit_tick),
    .ch1_os_tick(ch1_os_tick), .ch1_bit_tick(ch1_bit_tick)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Timer overflow generator
  always @(negedge clk) begin
    if (t1_cnt >= t1_per - 1) begin
      t1_cnt <= 0;
      t1_ovf <= 1'b1;
    end else begin
      t1_cnt <= t1_cnt + 1;
      t1_ovf <= 1'b0;
    end
  end

  // R6 / R7 monitor: bit tick on every 16th oversample tick
  always @(negedge clk) begin
    if (!rst) begin
      if (ch0_bit_tick) begin
        check("R6 ch0 bit with os", longint'(ch0_os_tick), 1);
        check("R6 ch0 os per bit", os_since0, 15);
        os_since0 = 0;
      end else if (ch0_os_tick) os_since0++;
      if (ch1_bit_tick) begin
        check("R6 ch1 bit with os", longint'(ch1_os_tick), 1);
        check("R6 ch1 os per bit", os_since1, 15);
        os_since1 = 0;
      end else if (ch1_os_tick) os_since1++;
    end
  end

  function automatic int exp_os0(int rel, bit dbl, bit src, int k);
    if (src) return k * (dbl ? 1 : 2);
    return (1024 - rel) * (dbl ? 2 : 4);
  endfunction

  function automatic int exp_os1(int rel);
    return 2 * (1024 - rel);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic set_rel(input int ch, input int rel);
    wr(3'(2 * ch), 8'(rel));
    wr(3'(2 * ch + 1), 8'(rel >> 8));
  endtask

  task automatic wait_os(input int ch, output int t);
    do @(negedge clk); while (!(ch == 0 ? ch0_os_tick : ch1_os_tick));
    t = cyc;
  endtask

  task automatic wait_bit(input int ch, output int t);
    do @(negedge clk); while (!(ch == 0 ? ch0_bit_tick : ch1_bit_tick));
    t = cyc;
  endtask

  task automatic measure(input int ch, input int exp, input string req, input int n);
    int t0, t1;
    wait_os(ch, t0);
    for (int i = 0; i < n; i++) begin
      wait_os(ch, t1);
      check(req, t1 - t0, exp);
      t0 = t1;
    end
  endtask

  task automatic flush();
    int t;
    for (int i = 0; i < 3; i++) wait_os(0, t);
    for (int i = 0; i < 3; i++) wait_os(1, t);
  endtask

  // Watchdog
  initial begin
    repeat (195000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=<195000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int t, t0, t1, r0, r1;
    bit dbl, src;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    check("R9 ticks low in reset", longint'({ch0_os_tick, ch0_bit_tick, ch1_os_tick, ch1_bit_tick}), 0);
    rst = 1'b0;
    check("R9 ticks low after reset", longint'({ch0_os_tick, ch0_bit_tick, ch1_os_tick, ch1_bit_tick}), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R9 register reset value", d, 0);
    end
    // R9: reload 0 gives the 1024-clock period, double off
    measure(1, 2048, "R9 ch1 default interval", 1);
    measure(0, 4096, "R9 ch0 default interval", 1);

    // R1 register map and masking
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R1 ch0 high masked", d, 8'h03);
    wr(3'd0, 8'hA5); rd(3'd0, d); check("R1 ch0 low", d, 8'hA5);
    wr(3'd4, 8'hFF); rd(3'd4, d); check("R1 ctrl masked", d, 8'h03);
    wr(3'd3, 8'h06); rd(3'd3, d); check("R1 ch1 high masked", d, 8'h02);
    wr(3'd6, 8'h5A); rd(3'd6, d); check("R1 unused address", d, 0);
    wr(3'd4, 8'h00);

    // R1/R2: high field used, REL1 = 0x2FF -> period 257
    set_rel(1, 32'h2FF);
    set_rel(0, 1018);
    flush();
    measure(1, 514, "R2 ch1 high field", 2);

    // R3: internal source, double off and on
    measure(0, 24, "R3 ch0 double off", 2);
    wr(3'd4, 8'h01);
    flush();
    measure(0, 12, "R3 ch0 double on", 2);
    measure(1, 514, "R5 ch1 ignores double", 1);

    // R4: timer source
    t1_per = 5;
    wr(3'd4, 8'h02);
    flush();
    measure(0, 10, "R4 ch0 timer double off", 2);
    wr(3'd4, 8'h03);
    flush();
    measure(0, 5, "R4 ch0 timer double on", 2);
    measure(1, 514, "R5 ch1 ignores timer source", 1);

    // R8: write inside a running period
    set_rel(1, 1004);
    flush();
    wait_os(1, t0);
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'(1014);
    @(negedge clk); wr_en = 1'b0;
    wait_os(1, t1); check("R8 mid-period write", t1 - t0, 30);
    t0 = t1;
    wait_os(1, t1); check("R8 new period", t1 - t0, 20);
    // R8: write sampled on the reload edge (reload at cyc t0 - 1 + 10)
    wait_os(1, t0);
    while (cyc < t0 + 8) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'(1004);
    @(negedge clk); wr_en = 1'b0;
    wait_os(1, t1); check("R8 same-edge write keeps old", t1 - t0, 20);
    t0 = t1;
    wait_os(1, t1); check("R8 same-edge write then new", t1 - t0, 40);

    // Random mixes
    for (int it = 0; it < 5; it++) begin
      r0 = $urandom_range(1000, 1023);
      r1 = $urandom_range(1000, 1023);
      dbl = 1'($urandom_range(0, 1));
      src = 1'($urandom_range(0, 1));
      t1_per = $urandom_range(1, 8);
      set_rel(0, r0);
      set_rel(1, r1);
      wr(3'd4, {6'd0, src, dbl});
      flush();
      measure(0, exp_os0(r0, dbl, src, t1_per), src ? "R4 random ch0" : "R3 random ch0", 2);
      measure(1, exp_os1(r1), "R5 random ch1", 2);
      wait_bit(0, t0); wait_bit(0, t1);
      check("R6 ch0 bit interval", t1 - t0, 16 * exp_os0(r0, dbl, src, t1_per));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule